// File: doc/BRIEF.md
# SPI Register Access Master

This block drives a single SPI slave that exposes its settings and results as 8-bit registers. A requester presents a register address, a write byte and a write/read flag, then pulses `start`. The block runs one whole bus transaction in SPI mode 0: SCLK idles low, the slave samples on the rising edge, and the master moves MOSI on the falling edge. A write frame is a command byte of 0x0A, the address and the data byte. A read frame is a command byte of 0x0B and the address, followed by eight bits shifted in from MISO. Every byte goes MSB first, so each transaction lasts 24 SCLK periods.

SCLK runs all the time, also between transactions. Its period is `SCLK_T` system clocks, with equal high and low halves. A transaction always begins on a falling SCLK edge. After the final falling edge, chip select stays low for a short hold count and then stays high for a disable count. Only after both counts does the block report completion with a one-cycle `done`. Read data appears on `rdData` in that same cycle.

Top module: `spi_reg_master`

## Requirements
- R1: `spiSclk` is low out of reset and toggles forever. It stays high for exactly `SCLK_T/2` clocks and low for exactly `SCLK_T/2` clocks.
- R2: Out of reset and while idle, `spiCsN` is 1 and `spiMosi` is 0. `spiCsN` falls only in the clock where `spiSclk` falls, and that is the first falling edge after `start` is accepted.
- R3: A write (`wrEn`=1) sends 0x0A, then `regAddr`, then `wrData` on `spiMosi`. Each byte goes MSB first, one bit per SCLK period, and `spiMosi` changes only where `spiSclk` falls.
- R4: A read (`wrEn`=0) sends 0x0B, then `regAddr`, then drives `spiMosi` to 0 for eight more periods. During those periods `spiMiso` is sampled on each rising SCLK edge and assembled MSB first.
- R5: After the last (24th) falling SCLK edge of a frame, `spiCsN` stays low for `HOLD_CYC` clocks and then goes high.
- R6: `done` is high for exactly one clock. That clock comes `GAP_CYC` clocks after `spiCsN` rises, and `spiCsN` is high in it.
- R7: After a read, `rdData` shows the received byte from the clock in which `done` is high. A write leaves `rdData` unchanged, and `rdData` changes at no other time.
- R8: `regAddr`, `wrData` and `wrEn` are captured in the clock in which `start` is accepted. Later changes have no effect on the frame in progress.
- R9: A `start` pulse given while a transaction is in progress is ignored. No second frame follows, and `spiCsN` stays high after `done`.
- R10: A `start` given in the clock right after `done` is accepted and produces a complete, correct frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request one transaction (accepted when idle) |
| wrEn | input | 1 | 1 = register write, 0 = register read |
| regAddr | input | 8 | Register address to access |
| wrData | input | 8 | Byte to write |
| rdData | output | 8 | Last byte read from the slave |
| done | output | 1 | One-cycle completion pulse |
| spiSclk | output | 1 | Serial clock, free running, idles low |
| spiMosi | output | 1 | Serial data to the slave |
| spiMiso | input | 1 | Serial data from the slave |
| spiCsN | output | 1 | Active-low chip select |

## Verification
The bench uses several stimulus patterns, and each one exposes a different class of fault.

- Writes with alternating address and data patterns show whether bits are dropped or swapped between bytes. The all-ones and all-zeros bytes show whether the stuck-at value in the shifter is wrong.
- Reads with slave bytes such as 0xA5 and 0x3C show whether MISO is sampled on the wrong edge or in the wrong order. MISO is held at 1 during the address phase, which shows whether the master samples too early.
- One transaction scrambles its inputs mid-frame. Another pulses `start` while the block is busy. A third is issued in the cycle after `done`. Together these separate input capture, busy rejection and idle re-entry from the plain frame logic.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_CMD,
    ST_ADDR,
    ST_DATA,
    ST_RX,
    ST_HOLD,
    ST_GAP
  } spiState_t;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic latchIn;
    logic loadCmd;
    logic loadAddr;
    logic loadData;
    logic shiftTx;
    logic clearTx;
    logic shiftRx;
    logic captureOut;
  } dpCtl_t;

endpackage

// File: rtl/spi_sclk_gen.sv
module spi_sclk_gen #(
  parameter int SCLK_T = 28
) (
  input  logic clk,
  input  logic rst_n,
  output logic sclk,
  output logic riseStb,
  output logic fallStb
);
  localparam int HALF  = SCLK_T / 2;
  localparam int CNT_W = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CNT_W-1:0] tCnt;
  logic             wrap;

  assign wrap    = (tCnt == CNT_W'(HALF - 1));
  // strobes mark the clock edge at which sclk changes level
  assign riseStb = wrap && !sclk;
  assign fallStb = wrap &&  sclk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tCnt <= '0;
      sclk <= 1'b0;
    end else if (wrap) begin
      tCnt <= '0;
      sclk <= !sclk;
    end else begin
      tCnt <= tCnt + 1'b1;
    end
  end
endmodule

// File: rtl/spi_reg_dpath.sv
module spi_reg_dpath
  import spi_reg_pkg::*;
#(
  parameter int              DATA_W = 8,
  parameter logic [DATA_W-1:0] CMD_WR = 8'h0A,
  parameter logic [DATA_W-1:0] CMD_RD = 8'h0B
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dpCtl_t            ctl,
  input  logic [DATA_W-1:0] regAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrEn,
  input  logic              miso,
  output logic              mosi,
  output logic              wrQ,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;
  logic [DATA_W-1:0] txReg;
  logic [DATA_W-1:0] rxReg;

  assign mosi = txReg[DATA_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addrQ <= '0;
      dataQ <= '0;
      wrQ   <= 1'b0;
    end else if (ctl.latchIn) begin
      addrQ <= regAddr;
      dataQ <= wrData;
      wrQ   <= wrEn;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txReg <= '0;
    end else if (ctl.clearTx) begin
      txReg <= '0;
    end else if (ctl.loadCmd) begin
      txReg <= wrQ ? CMD_WR : CMD_RD;
    end else if (ctl.loadAddr) begin
      txReg <= addrQ;
    end else if (ctl.loadData) begin
      txReg <= dataQ;
    end else if (ctl.shiftTx) begin
      txReg <= {txReg[DATA_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxReg <= '0;
    end else if (ctl.shiftRx) begin
      rxReg <= {rxReg[DATA_W-2:0], miso};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdData <= '0;
    end else if (ctl.captureOut) begin
      rdData <= rxReg;
    end
  end
endmodule

// File: rtl/spi_reg_ctrl.sv
module spi_reg_ctrl
  import spi_reg_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int HOLD_CYC = 2,
  parameter int GAP_CYC  = 2
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  logic   riseStb,
  input  logic   fallStb,
  input  logic   wrQ,
  output dpCtl_t ctl,
  output logic   csN,
  output logic   done
);
  localparam int BIT_W  = (DATA_W > 2) ? $clog2(DATA_W) : 1;
  localparam int MAXW   = (HOLD_CYC > GAP_CYC) ? HOLD_CYC : GAP_CYC;
  localparam int WAIT_W = $clog2(MAXW + 1);

  spiState_t         state, stNext;
  logic [BIT_W-1:0]  bitCnt;
  logic [WAIT_W-1:0] waitCnt;
  logic              lastBit;
  logic              inFrame;

  assign lastBit = (bitCnt == BIT_W'(DATA_W - 1));
  assign inFrame = (state == ST_CMD) || (state == ST_ADDR) ||
                   (state == ST_DATA) || (state == ST_RX);

  always_comb begin
    ctl    = '0;
    stNext = state;
    unique case (state)
      ST_IDLE: if (start) begin
        ctl.latchIn = 1'b1;
        stNext      = ST_ARM;
      end
      ST_ARM: if (fallStb) begin
        ctl.loadCmd = 1'b1;
        stNext      = ST_CMD;
      end
      ST_CMD: if (fallStb) begin
        if (lastBit) begin
          ctl.loadAddr = 1'b1;
          stNext       = ST_ADDR;
        end else begin
          ctl.shiftTx = 1'b1;
        end
      end
      ST_ADDR: if (fallStb) begin
        if (lastBit && wrQ) begin
          ctl.loadData = 1'b1;
          stNext       = ST_DATA;
        end else if (lastBit) begin
          ctl.clearTx = 1'b1;
          stNext      = ST_RX;
        end else begin
          ctl.shiftTx = 1'b1;
        end
      end
      ST_DATA: if (fallStb) begin
        if (lastBit) begin
          ctl.clearTx = 1'b1;
          stNext      = ST_HOLD;
        end else begin
          ctl.shiftTx = 1'b1;
        end
      end
      ST_RX: begin
        ctl.shiftRx = riseStb;
        if (fallStb && lastBit) stNext = ST_HOLD;
      end
      ST_HOLD: if (waitCnt == WAIT_W'(HOLD_CYC - 1)) stNext = ST_GAP;
      ST_GAP: if (waitCnt == WAIT_W'(GAP_CYC - 1)) begin
        ctl.captureOut = !wrQ;
        stNext         = ST_IDLE;
      end
      default: stNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      bitCnt  <= '0;
      waitCnt <= '0;
      csN     <= 1'b1;
      done    <= 1'b0;
    end else begin
      state <= stNext;
      if (state == ST_ARM)          bitCnt <= '0;
      else if (inFrame && fallStb)  bitCnt <= bitCnt + 1'b1;
      if (state != stNext)          waitCnt <= '0;
      else if (state == ST_HOLD || state == ST_GAP) waitCnt <= waitCnt + 1'b1;
      if (state == ST_ARM && fallStb)                csN <= 1'b0;
      else if (state == ST_HOLD && stNext == ST_GAP) csN <= 1'b1;
      done <= (state == ST_GAP) && (stNext == ST_IDLE);
    end
  end
endmodule

// File: rtl/spi_reg_master.sv
module spi_reg_master
  import spi_reg_pkg::*;
#(
  parameter int SCLK_T   = 28,
  parameter int HOLD_CYC = 2,
  parameter int GAP_CYC  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       wrEn,
  input  logic [7:0] regAddr,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  output logic       done,
  output logic       spiSclk,
  output logic       spiMosi,
  input  logic       spiMiso,
  output logic       spiCsN
);
  localparam int DATA_W = 8;

  dpCtl_t ctl;
  logic   riseStb;
  logic   fallStb;
  logic   wrQ;

  spi_sclk_gen #(.SCLK_T(SCLK_T)) u_sclk (
    .clk     (clk),
    .rst_n   (rst_n),
    .sclk    (spiSclk),
    .riseStb (riseStb),
    .fallStb (fallStb)
  );

  spi_reg_ctrl #(
    .DATA_W   (DATA_W),
    .HOLD_CYC (HOLD_CYC),
    .GAP_CYC  (GAP_CYC)
  ) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .riseStb (riseStb),
    .fallStb (fallStb),
    .wrQ     (wrQ),
    .ctl     (ctl),
    .csN     (spiCsN),
    .done    (done)
  );

  spi_reg_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctl     (ctl),
    .regAddr (regAddr),
    .wrData  (wrData),
    .wrEn    (wrEn),
    .miso    (spiMiso),
    .mosi    (spiMosi),
    .wrQ     (wrQ),
    .rdData  (rdData)
  );
endmodule

// File: rtl/spi_reg_master_chk.sv
module spi_reg_master_chk #(
  parameter int SCLK_T = 28
) (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] rdData,
  input logic       done,
  input logic       spiSclk,
  input logic       spiMosi,
  input logic       spiCsN
);
  localparam int HALF = SCLK_T / 2;

  int lowRun;
  int highRun;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lowRun  <= 0;
      highRun <= 0;
    end else begin
      lowRun  <= spiSclk ? 0 : lowRun + 1;
      highRun <= spiSclk ? highRun + 1 : 0;
    end
  end

  assert_sclk_low_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spiSclk) |-> lowRun == HALF);
  assert_sclk_high_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spiSclk) |-> highRun == HALF);
  assert_idle_mosi_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    spiCsN |-> !spiMosi);
  assert_cs_fall_on_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spiCsN) |-> $fell(spiSclk));
  assert_mosi_moves_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(spiMosi) |-> $fell(spiSclk));
  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_cs_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> spiCsN);
  assert_rddata_only_at_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rdData) |-> done);
endmodule

bind spi_reg_master spi_reg_master_chk #(.SCLK_T(SCLK_T)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .rdData  (rdData),
  .done    (done),
  .spiSclk (spiSclk),
  .spiMosi (spiMosi),
  .spiCsN  (spiCsN)
);

// File: tb/spi_reg_master_tb.sv
`timescale 1ns/1ps
module spi_reg_master_tb;
  localparam int T    = 28;
  localparam int HALF = T / 2;
  localparam int HOLD = 2;
  localparam int GAP  = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] regAddr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       done;
  logic       spiSclk;
  logic       spiMosi;
  logic       spiMiso = 1'b1;
  logic       spiCsN;

  int checks = 0;
  int errors = 0;
  int cycle  = 0;

  always #10 clk = ~clk;

  spi_reg_master #(.SCLK_T(T), .HOLD_CYC(HOLD), .GAP_CYC(GAP)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .wrEn(wrEn), .regAddr(regAddr),
    .wrData(wrData), .rdData(rdData), .done(done), .spiSclk(spiSclk),
    .spiMosi(spiMosi), .spiMiso(spiMiso), .spiCsN(spiCsN)
  );

  // behavioural reference model
  logic        mSclk, mCsn, mMosi, mDone, mWr, prevSclk;
  logic [7:0]  mOdata, mRx, slaveByte;
  logic [23:0] frame;
  int          mCnt, phase, k, h, g;
  logic        fallE, riseE;
  logic        capQ[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      mSclk = 0; mCnt = 0; phase = 0; k = 0; h = 0; g = 0;
      mCsn = 1; mMosi = 0; mDone = 0; mOdata = 0; mRx = 0; mWr = 0; frame = 0;
    end else begin
      fallE = (mCnt == HALF - 1) && mSclk;
      riseE = (mCnt == HALF - 1) && !mSclk;
      if (mCnt == HALF - 1) begin mCnt = 0; mSclk = !mSclk; end
      else mCnt++;
      mDone = 0;
      case (phase)
        0: if (start) begin
          mWr = wrEn;
          frame = {(wrEn ? 8'h0A : 8'h0B), regAddr, (wrEn ? wrData : 8'h00)};
          phase = 1;
        end
        1: if (fallE) begin
          phase = 2; mCsn = 0; k = 0; mMosi = frame[23];
        end
        2: begin
          if (riseE && k >= 16 && !mWr) mRx = {mRx[6:0], spiMiso};
          if (fallE) begin
            k++;
            if (k == 24) begin phase = 3; h = 0; mMosi = 0; end
            else mMosi = frame[23-k];
          end
        end
        3: if (h == HOLD - 1) begin mCsn = 1; phase = 4; g = 0; end
           else h++;
        4: if (g == GAP - 1) begin
             mDone = 1; phase = 0;
             if (!mWr) mOdata = mRx;
           end else g++;
        default: phase = 0;
      endcase
    end
  end

  task automatic fail(string req, string what, int act, int exp);
    errors++;
    $display("FAIL %s %s: actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, cycle);
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // per-cycle comparison and slave model
  always @(negedge clk) begin
    cycle++;
    if (rst_n) begin
      checks++;
      if (spiSclk !== mSclk) fail("R1", "sclk", spiSclk, mSclk);
      if (spiCsN !== mCsn)   fail("R2/R5", "csn", spiCsN, mCsn);
      if (spiMosi !== mMosi) fail("R3/R4", "mosi", spiMosi, mMosi);
      if (done !== mDone)    fail("R6", "done", done, mDone);
      if (rdData !== mOdata) fail("R7", "rdData", rdData, mOdata);
      if (mSclk && !prevSclk && phase == 2) capQ.push_back(spiMosi);
    end
    prevSclk = mSclk;
    if (phase == 2 && k >= 16 && k < 24) spiMiso = slaveByte[23-k];
    else spiMiso = 1'b1;
    if (cycle > 150000) begin
      fail("WDG", "watchdog", cycle, 150000);
      finishRun();
    end
  end

  task automatic runTxn(input logic wr, input logic [7:0] addr, input logic [7:0] dat,
                        input logic [7:0] sb, input bit scramble, input bit busyStart,
                        input string req);
    logic [23:0] expFrame;
    logic [23:0] got;
    logic [7:0]  prevOut;
    prevOut  = mOdata;
    expFrame = {(wr ? 8'h0A : 8'h0B), addr, (wr ? dat : 8'h00)};
    capQ.delete();
    @(negedge clk);
    start = 1; wrEn = wr; regAddr = addr; wrData = dat; slaveByte = sb;
    @(negedge clk);
    start = 0;
    if (scramble) begin wrEn = !wr; regAddr = ~addr; wrData = ~dat; end
    if (busyStart) begin
      repeat (300) @(negedge clk);
      start = 1; wrEn = !wr; regAddr = 8'h33; wrData = 8'h44;
      @(negedge clk);
      start = 0;
    end
    while (!mDone) @(negedge clk);
    checks++;
    got = '0;
    for (int i = 0; i < capQ.size() && i < 24; i++) got[23-i] = capQ[i];
    if (capQ.size() != 24 || got !== expFrame)
      fail(req, "frame bits", int'(got), int'(expFrame));
    checks++;
    if (done !== 1'b1 || spiCsN !== 1'b1) fail("R6", "done/csn at end", {done, spiCsN}, 3);
    checks++;
    if (wr && rdData !== prevOut) fail("R7", "rdData after write", rdData, prevOut);
    if (!wr && rdData !== sb)     fail("R7", "rdData after read", rdData, sb);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // reset state (R2)
    checks++;
    if (spiCsN !== 1 || spiMosi !== 0 || done !== 0 || rdData !== 0 || spiSclk !== 0)
      fail("R2", "reset state", {spiCsN, spiMosi, done, spiSclk}, 8);
    rst_n = 1;
    repeat (40) @(negedge clk);
    runTxn(1, 8'h2D, 8'h02, 8'h00, 0, 0, "R3");
    repeat (50) @(negedge clk);
    runTxn(0, 8'h08, 8'h00, 8'hA5, 0, 0, "R4");
    repeat (17) @(negedge clk);
    runTxn(1, 8'hFF, 8'h00, 8'h00, 0, 0, "R3");
    runTxn(0, 8'h5A, 8'h77, 8'h3C, 0, 0, "R10");
    runTxn(1, 8'h00, 8'hFF, 8'h00, 0, 0, "R10");
    repeat (9) @(negedge clk);
    runTxn(0, 8'h0B, 8'h00, 8'hFF, 1, 0, "R8");
    runTxn(1, 8'hC3, 8'h96, 8'h00, 1, 0, "R8");
    repeat (5) @(negedge clk);
    runTxn(0, 8'h1F, 8'h52, 8'h00, 0, 1, "R9");
    // after the ignored start, no further frame may follow (R9)
    repeat (3 * T) begin
      @(negedge clk);
      checks++;
      if (spiCsN !== 1'b1) fail("R9", "csn after ignored start", spiCsN, 1);
    end
    runTxn(0, 8'h81, 8'h00, 8'h69, 0, 0, "R4");
    repeat (20) @(negedge clk);
    finishRun();
  end
endmodule